// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block gives a processor three 8-bit parallel ports through a small register window: two full-width data ports (A and B) and a third port (C) that is handled as two 4-bit halves. The processor side is a synchronous bus with chip select, read and write strobes, a two-bit address and an 8-bit data bus. The pad side is modelled as separate input, output and output-enable vectors for every port, so the pads can be built outside the block.

The lines are split into two groups that are configured as units: group A owns port A and the upper half of port C, group B owns port B and the lower half. A single write-only configuration address accepts either a mode word, which sets each group's mode and the direction of each port or half, or a single-bit command that sets or clears one port C output bit. Each group runs either plain latched/unlatched I/O (mode 0) or strobed transfers (mode 1), where three of its port C lines become a strobe or acknowledge input, a buffer status output and an interrupt request output.

All bus accesses are sampled on the rising clock edge in the cycle where `cs` and the strobe are high; read data is combinational from the address. Handshake inputs are sampled synchronously and are active low.

Top module: `tri_port_pio`

## Requirements
- R1: After reset every port and half is a mode 0 input: `pa_oe`, `pb_oe` and `pc_oe` are all zero and every output latch is zero.
- R2: Address 2'b11 is the write-only configuration address; a read there returns 8'h00, and `rdata` is 8'h00 whenever no read is in progress.
- R3: A configuration write with bit 7 = 1 is a mode word: bits 6:5 pick the group A mode (2'b01 = mode 1, any other value = mode 0), bit 4 port A direction, bit 3 upper port C direction, bit 2 group B mode (1 = mode 1), bit 1 port B direction, bit 0 lower port C direction; a direction bit of 1 means input (enables low), 0 means output (enables high on all lines of that port or half).
- R4: Every mode word clears the port A, B and C output latches and all handshake buffer flags to zero.
- R5: A configuration write with bit 7 = 0 writes bit 0 into port C output latch bit number bits 3:1, ignores bits 6:4, and changes no other latch bit and no configuration.
- R6: Address 2'b00 is port A, 2'b01 port B, 2'b10 port C. A write always loads the port's output latch, which drives the output pins; a read of an output port returns its latch; a read of a mode 0 input port returns the live pins.
- R7: A read of port C returns, per bit, the value the block drives when that bit's enable is high, and the pin input otherwise.
- R8: In mode 1 input, a low strobe at a clock edge (group A: PC4, group B: PC2) captures the port pins into an input latch and sets the buffer-full output high (group A: PC5, group B: PC1); a read of the port returns the captured value and clears buffer-full at that edge unless a strobe arrives in the same cycle.
- R9: In mode 1 output, a write to the port drives the active-low buffer-full output low (group A: PC7, group B: PC1); a low acknowledge at a clock edge (group A: PC6, group B: PC2) returns it high.
- R10: The interrupt output (group A: PC3, group B: PC0) is high when the enable bit is set and, in input mode, the buffer is full and the strobe is high, or in output mode, the buffer is empty and the acknowledge is high. The enable bit is the port C output latch bit at the strobe or acknowledge position (group A input: bit 4, group A output: bit 6, group B: bit 2).
- R11: In mode 1 the port C lines a group does not use for handshake keep the direction its half's direction bit gives; PC3 belongs to group A's interrupt when group A is in mode 1, and group B's lower direction bit then has no effect on PC0 to PC2 in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies rd and wr |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin outputs |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin outputs |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C pin outputs |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench builds the block with its default 8-bit port width, which keeps the whole configuration space small enough to sweep: every one of the 128 mode words is written, and the enables and driven values of all three ports are compared with values derived bit by bit from the mode word. All eight port C bit positions are set and cleared with varied values in the ignored field, and both handshake directions are run on both groups, including the strobe-held-low and read-clears cases and the reserved group A mode field.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PW = 8;
    localparam int HW = PW / 2;
    localparam int BW = $clog2(PW);

    localparam logic [1:0] ADDR_A   = 2'b00;
    localparam logic [1:0] ADDR_B   = 2'b01;
    localparam logic [1:0] ADDR_C   = 2'b10;
    localparam logic [1:0] ADDR_CTL = 2'b11;

    typedef struct packed {
        logic a_m1;   // group A strobed mode
        logic a_in;   // port A is input
        logic cu_in;  // upper port C half is input
        logic b_m1;   // group B strobed mode
        logic b_in;   // port B is input
        logic cl_in;  // lower port C half is input
    } cfg_t;

    localparam cfg_t CFG_RST = '{a_m1: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                 b_m1: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pio_cfg.sv
module pio_cfg
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [PW-1:0] wdata,
    output cfg_t          cfg,
    output logic          mode_load,
    output logic          bsr_load
);
    typedef struct packed {
        cfg_t cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        mode_load = ctl_wr && wdata[PW-1];
        bsr_load  = ctl_wr && !wdata[PW-1];
        st_d      = st_q;
        if (mode_load) begin
            st_d.cfg.a_m1  = (wdata[6:5] == 2'b01);
            st_d.cfg.a_in  = wdata[4];
            st_d.cfg.cu_in = wdata[3];
            st_d.cfg.b_m1  = wdata[2];
            st_d.cfg.b_in  = wdata[1];
            st_d.cfg.cl_in = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_RST};
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    // R5: a single-bit command leaves the configuration alone
    p_bsr_keeps_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_load |=> $stable(cfg));

    // R3: a mode word with the reserved group A field selects mode 0
    p_reserved_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && wdata[6]) |=> !cfg.a_m1);
endmodule

// File: rtl/pio_hs.sv
module pio_hs
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          mode1,
    input  logic          is_in,
    input  logic [PW-1:0] pin_in,
    input  logic          wr_port,
    input  logic          rd_port,
    input  logic [PW-1:0] wdata,
    input  logic          hs_n,
    input  logic          inte,
    output logic [PW-1:0] out_q,
    output logic [PW-1:0] in_q,
    output logic          full,
    output logic          intr
);
    typedef struct packed {
        logic [PW-1:0] outl;
        logic [PW-1:0] inl;
        logic          full;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (wr_port) st_d.outl = wdata;
            if (mode1 && is_in) begin
                if (rd_port) st_d.full = 1'b0;
                if (!hs_n) begin
                    st_d.inl  = pin_in;
                    st_d.full = 1'b1;
                end
            end else if (mode1) begin
                if (!hs_n)   st_d.full = 1'b0;
                if (wr_port) st_d.full = 1'b1;
            end else begin
                st_d.full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_q = st_q.outl;
    assign in_q  = st_q.inl;
    assign full  = st_q.full;
    assign intr  = inte && mode1 && hs_n && (is_in ? st_q.full : !st_q.full);

    // R8: a strobe in input mode leaves the buffer full
    p_strobe_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && is_in && !hs_n && !clear) |=> full);

    // R8: the captured value equals the pins at the strobe edge
    p_strobe_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && is_in && !hs_n && !clear) |=> (in_q == $past(pin_in)));

    // R9: a port write in output mode marks the buffer full
    p_write_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && !is_in && wr_port && !clear) |=> full);

    // R4: a mode word empties the buffer and clears the latch
    p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!full && out_q == '0));
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);
    localparam int NG = 2;

    typedef struct packed {
        logic [PW-1:0] pc;
    } st_t;

    st_t  st_d, st_q;
    cfg_t cfg;
    logic ctl_wr, mode_load, bsr_load;

    logic [NG-1:0] g_m1, g_in, g_hs, g_inte, g_wr, g_rd, g_full, g_intr;
    logic [PW-1:0] g_pin [NG];
    logic [PW-1:0] g_out [NG];
    logic [PW-1:0] g_inl [NG];

    assign ctl_wr = cs && wr && (addr == ADDR_CTL);

    pio_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .wdata     (wdata),
        .cfg       (cfg),
        .mode_load (mode_load),
        .bsr_load  (bsr_load)
    );

    // port C output latch
    always_comb begin
        st_d = st_q;
        if (mode_load)
            st_d.pc = '0;
        else if (bsr_load)
            st_d.pc[wdata[BW:1]] = wdata[0];
        else if (cs && wr && addr == ADDR_C)
            st_d.pc = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // per-group handshake hookup: index 0 is group A, 1 is group B
    always_comb begin
        g_m1     = {cfg.b_m1, cfg.a_m1};
        g_in     = {cfg.b_in, cfg.a_in};
        g_hs[0]  = cfg.a_in ? pc_in[4] : pc_in[6];
        g_hs[1]  = pc_in[2];
        g_inte[0] = cfg.a_in ? st_q.pc[4] : st_q.pc[6];
        g_inte[1] = st_q.pc[2];
        g_wr     = {cs && wr && addr == ADDR_B, cs && wr && addr == ADDR_A};
        g_rd     = {cs && rd && addr == ADDR_B, cs && rd && addr == ADDR_A};
        g_pin[0] = pa_in;
        g_pin[1] = pb_in;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        pio_hs u_hs (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (mode_load),
            .mode1   (g_m1[g]),
            .is_in   (g_in[g]),
            .pin_in  (g_pin[g]),
            .wr_port (g_wr[g]),
            .rd_port (g_rd[g]),
            .wdata   (wdata),
            .hs_n    (g_hs[g]),
            .inte    (g_inte[g]),
            .out_q   (g_out[g]),
            .in_q    (g_inl[g]),
            .full    (g_full[g]),
            .intr    (g_intr[g])
        );
    end

    assign pa_out = g_out[0];
    assign pb_out = g_out[1];
    assign pa_oe  = {PW{!cfg.a_in}};
    assign pb_oe  = {PW{!cfg.b_in}};

    // port C drive: direction per half, then handshake overrides
    always_comb begin
        pc_oe  = {{HW{!cfg.cu_in}}, {HW{!cfg.cl_in}}};
        pc_out = st_q.pc;
        if (cfg.b_m1) begin
            pc_oe[2]  = 1'b0;
            pc_oe[1]  = 1'b1;
            pc_oe[0]  = 1'b1;
            pc_out[1] = cfg.b_in ? g_full[1] : !g_full[1];
            pc_out[0] = g_intr[1];
        end
        if (cfg.a_m1) begin
            pc_oe[3]  = 1'b1;
            pc_out[3] = g_intr[0];
            if (cfg.a_in) begin
                pc_oe[4]  = 1'b0;
                pc_oe[5]  = 1'b1;
                pc_out[5] = g_full[0];
            end else begin
                pc_oe[6]  = 1'b0;
                pc_oe[7]  = 1'b1;
                pc_out[7] = !g_full[0];
            end
        end
    end

    // read path
    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            unique case (addr)
                ADDR_A:  rdata = cfg.a_in ? (cfg.a_m1 ? g_inl[0] : pa_in) : g_out[0];
                ADDR_B:  rdata = cfg.b_in ? (cfg.b_m1 ? g_inl[1] : pb_in) : g_out[1];
                ADDR_C:  rdata = (pc_oe & pc_out) | (~pc_oe & pc_in);
                default: rdata = '0;
            endcase
        end
    end

    // R4: a mode word clears every output latch
    p_mode_word_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> (st_q.pc == '0 && pa_out == '0 && pb_out == '0));

    // R5: a single-bit command flips at most one port C latch bit
    p_bsr_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_load |=> ($countones(st_q.pc ^ $past(st_q.pc)) <= 1));

    // R3: a port drives all its lines or none
    p_port_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pa_oe) == 0 || $countones(pa_oe) == PW) &&
        ($countones(pb_oe) == 0 || $countones(pb_oe) == PW));

    // R10: no group A interrupt while its strobe is held low in input mode
    p_intr_quiet_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.a_m1 && cfg.a_in && !pc_in[4]) |-> !pc_out[3]);
endmodule

// File: tb/sim_tri_port_pio.sv
module sim_tri_port_pio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tri_port_pio u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    // expected enables of port C from a mode word (R3, R11)
    function automatic logic [7:0] exp_pc_oe(input logic [7:0] cw);
        logic [7:0] oe;
        oe = {{4{~cw[3]}}, {4{~cw[0]}}};
        if (cw[2]) begin
            oe[2] = 1'b0; oe[1] = 1'b1; oe[0] = 1'b1;
        end
        if (cw[6:5] == 2'b01) begin
            oe[3] = 1'b1;
            if (cw[4]) begin oe[4] = 1'b0; oe[5] = 1'b1; end
            else       begin oe[6] = 1'b0; oe[7] = 1'b1; end
        end
        return oe;
    endfunction

    // expected port C drive right after a mode word (R4, R9)
    function automatic logic [7:0] exp_pc_out(input logic [7:0] cw);
        logic [7:0] o;
        o = 8'h00;
        if (cw[2] && !cw[1]) o[1] = 1'b1;
        if (cw[6:5] == 2'b01 && !cw[4]) o[7] = 1'b1;
        return o;
    endfunction

    initial begin
        logic [7:0] v;
        logic [7:0] pc_model;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        pa_in = 8'h5A;
        bus_rd(2'b00, v);
        chk("R1 read A live", v, 8'h5A);
        // R2: config address not readable, idle rdata zero
        bus_rd(2'b11, v);
        chk("R2 ctl read", v, 8'h00);
        #1 chk("R2 idle rdata", rdata, 8'h00);

        // R3 R4 R11: sweep every mode word
        pc_in = 8'hFF;
        for (int i = 0; i < 128; i++) begin
            logic [7:0] cw;
            cw = 8'h80 | i[7:0];
            bus_wr(2'b00, 8'hFF);
            bus_wr(2'b01, 8'hFF);
            bus_wr(2'b10, 8'hFF);
            bus_wr(2'b11, cw);
            chk("R3 pa_oe", pa_oe, cw[4] ? 8'h00 : 8'hFF);
            chk("R3 pb_oe", pb_oe, cw[1] ? 8'h00 : 8'hFF);
            chk("R11 pc_oe", pc_oe, exp_pc_oe(cw));
            chk("R4 pa_out", pa_out, 8'h00);
            chk("R4 pb_out", pb_out, 8'h00);
            chk("R4 pc_out", pc_out, exp_pc_out(cw));
        end

        // R6: mode 0 outputs and inputs
        bus_wr(2'b11, 8'h80);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            d = 8'h11 * k[7:0] + 8'h3C;
            bus_wr(2'b00, d);
            chk("R6 pa_out", pa_out, d);
            bus_rd(2'b00, v);
            chk("R6 read A latch", v, d);
            bus_wr(2'b01, ~d);
            chk("R6 pb_out", pb_out, ~d);
        end
        bus_wr(2'b11, 8'h92);
        for (int k = 0; k < 4; k++) begin
            pa_in = 8'h21 * k[7:0] + 8'h05;
            pb_in = ~pa_in;
            bus_rd(2'b00, v);
            chk("R6 read A pins", v, pa_in);
            bus_rd(2'b01, v);
            chk("R6 read B pins", v, pb_in);
        end
        bus_wr(2'b00, 8'hC3);
        chk("R6 input A latch loads", pa_out, 8'hC3);
        chk("R6 input A not driven", pa_oe, 8'h00);

        // R7: port C mixed read, upper input lower output
        bus_wr(2'b11, 8'h88);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            d = 8'h5B + 8'h37 * k[7:0];
            pc_in = 8'h3C ^ (8'h44 * k[7:0]);
            bus_wr(2'b10, d);
            bus_rd(2'b10, v);
            chk("R7 read C", v, {pc_in[7:4], d[3:0]});
        end
        pc_in = 8'hFF;

        // R5: single-bit set/reset on every bit
        bus_wr(2'b11, 8'h80);
        bus_wr(2'b00, 8'h5A);
        pc_model = 8'h00;
        for (int b = 0; b < 8; b++) begin
            for (int val = 1; val >= 0; val--) begin
                logic [7:0] cmd;
                cmd = {1'b0, 3'(b * 3 + val), 3'(b), 1'(val)};
                bus_wr(2'b11, cmd);
                pc_model[b] = 1'(val);
                chk("R5 pc_out bit", pc_out, pc_model);
                if (val == 1) pc_model[(b + 3) % 8] = 1'b1;
                if (val == 1) bus_wr(2'b11, {1'b0, 3'b111, 3'((b + 3) % 8), 1'b1});
            end
            chk("R5 pa_out untouched", pa_out, 8'h5A);
            chk("R5 pa_oe untouched", pa_oe, 8'hFF);
        end

        // R8 R10: group A strobed input
        pc_in = 8'hFF;
        bus_wr(2'b11, 8'hB0);
        bus_wr(2'b11, 8'h09);          // enable bit 4
        chk("R10 A intr idle", {7'h0, pc_out[3]}, 8'h00);
        pa_in = 8'h3C;
        @(negedge clk); pc_in = 8'hEF;
        @(negedge clk);
        chk("R8 A full during strobe", {7'h0, pc_out[5]}, 8'h01);
        chk("R10 A intr held by strobe", {7'h0, pc_out[3]}, 8'h00);
        pc_in = 8'hFF;
        #1 chk("R10 A intr after strobe", {7'h0, pc_out[3]}, 8'h01);
        pa_in = 8'h00;
        bus_rd(2'b00, v);
        chk("R8 A captured value", v, 8'h3C);
        chk("R8 A full cleared", {7'h0, pc_out[5]}, 8'h00);
        chk("R10 A intr cleared", {7'h0, pc_out[3]}, 8'h00);

        // R3: reserved group A field behaves as mode 0
        bus_wr(2'b11, 8'hD0);
        pa_in = 8'h77;
        @(negedge clk); pc_in = 8'hEF;
        @(negedge clk); pc_in = 8'hFF;
        chk("R3 reserved mode no handshake", pc_out, 8'h00);
        pa_in = 8'h12;
        bus_rd(2'b00, v);
        chk("R3 reserved mode live read", v, 8'h12);

        // R9 R10: group B strobed output
        bus_wr(2'b11, 8'h84);
        chk("R9 B empty after mode", {7'h0, pc_out[1]}, 8'h01);
        bus_wr(2'b11, 8'h05);          // enable bit 2
        chk("R10 B intr empty", {7'h0, pc_out[0]}, 8'h01);
        bus_wr(2'b01, 8'h77);
        chk("R9 B data", pb_out, 8'h77);
        chk("R9 B full", {7'h0, pc_out[1]}, 8'h00);
        chk("R10 B intr full", {7'h0, pc_out[0]}, 8'h00);
        @(negedge clk); pc_in = 8'hFB;
        @(negedge clk);
        chk("R9 B ack empties", {7'h0, pc_out[1]}, 8'h01);
        chk("R10 B intr held by ack", {7'h0, pc_out[0]}, 8'h00);
        pc_in = 8'hFF;
        #1 chk("R10 B intr after ack", {7'h0, pc_out[0]}, 8'h01);

        // R8: group B strobed input
        bus_wr(2'b11, 8'h86);
        pb_in = 8'hA6;
        @(negedge clk); pc_in = 8'hFB;
        @(negedge clk); pc_in = 8'hFF;
        chk("R8 B full", {7'h0, pc_out[1]}, 8'h01);
        pb_in = 8'h00;
        bus_rd(2'b01, v);
        chk("R8 B captured", v, 8'hA6);
        chk("R8 B full cleared", {7'h0, pc_out[1]}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule